// File: doc/BRIEF.md
# Simulation Control Port Block

This block sits on the I/O bus of an 8-bit processor and lets the program under test steer its own test run. Writes land in a 32-port window. A command port turns byte codes into one-cycle pass, fail, dump-start and dump-stop pulses. A message port collects characters into a line buffer, and a newline releases the collected line. A watchdog counter raises a timeout error when it reaches a programmable 16-bit limit. A separate countdown drives an active-low interrupt line low after a programmed number of clocks.

Pass, fail and timeout all feed one sticky completion flag. Whichever of them happens first decides the final status that the surrounding environment reports. The enclosing test harness watches the pulses, the line outputs and the completion flags. It reads each finished line out through an index port, and it prints text or stops the simulator itself.

Top module: `simctl_port`

## Requirements
- R1: Only writes with address bits [7:5] equal to 3'b100 (ports 0x80 to 0x9F) have any effect. Any write outside that window changes no output. Within the window, only offsets 0x00, 0x01, 0x02, 0x03, 0x04 and 0x10 have any effect.
- R2: A write to port 0x80 with data 0x01, 0x02, 0x03 or 0x04 raises pass_pulse, fail_pulse, dump_on_pulse or dump_off_pulse respectively. The pulse is high for exactly the one cycle after the write edge. Any other data value raises no pulse.
- R3: dump_active is 0 after reset. It becomes 1 after command 0x03 and 0 after command 0x04, and other command values leave it unchanged.
- R4: Pass, fail and timeout each set the sticky done flag. The first of them (pass before fail before timeout within one cycle) sets exactly one of done_pass, done_fail and done_timeout, and later events leave all four flags unchanged until reset.
- R5: Each non-newline byte written to port 0x81 is appended to the line buffer. A write of 0x0A is not stored. It raises line_valid for one cycle, presents the stored length on line_len (held until the next newline), and empties the buffer. Character i of the line is then readable on line_rd_char with line_rd_idx = i.
- R6: Once LINE_DEPTH characters are buffered, further characters are dropped until the next newline, and line_len never exceeds LINE_DEPTH.
- R7: At port 0x82, bit 0 sets the watchdog enable and bit 1 zeroes the counter for that write only. A disabled counter holds its value. Reading port 0x82 returns the enable in bit 0 and zero in the other bits.
- R8: After reset the watchdog is enabled, its counter is 0 and its limit is TMO_RESET. After the counter is cleared with the watchdog enabled, timeout_error rises on the (M+1)-th clock edge, where M is the limit. timeout_error then stays high until reset.
- R9: The 16-bit limit is written with its low byte at port 0x83 and its high byte at port 0x84. While io_rd is high, io_rdata returns the addressed byte. Unmapped reads return 0.
- R10: A nonzero write N to port 0x90 drives int_n high and starts a countdown. int_n goes low on the N-th clock edge after the write edge and stays low until port 0x90 is written again.
- R11: A zero write to port 0x90 cancels any pending countdown and drives int_n high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data (combinational) |
| pass_pulse | output | 1 | One-cycle pass command |
| fail_pulse | output | 1 | One-cycle fail command |
| dump_on_pulse | output | 1 | One-cycle dump-start command |
| dump_off_pulse | output | 1 | One-cycle dump-stop command |
| dump_active | output | 1 | Dump requested level |
| done | output | 1 | Sticky completion flag |
| done_pass | output | 1 | Completed by pass |
| done_fail | output | 1 | Completed by fail |
| done_timeout | output | 1 | Completed by timeout |
| timeout_error | output | 1 | Sticky watchdog expiry |
| line_valid | output | 1 | One-cycle complete-line strobe |
| line_len | output | $clog2(LINE_DEPTH+1) | Length of the last completed line |
| line_rd_idx | input | $clog2(LINE_DEPTH) | Line buffer read index |
| line_rd_char | output | 8 | Buffered character at line_rd_idx |
| int_n | output | 1 | Active-low countdown interrupt |

## Verification
The bench builds the block with LINE_DEPTH = 8 and TMO_RESET = 300. With these values, line overflow is reached with lines only a few characters long, and the expiry of the default watchdog after reset can be timed to the exact cycle. Under that configuration, the bench sweeps every command byte value, every countdown value from 1 to 255 and line lengths from 0 to 12. Watchdog limits from 0 to 40 are swept as well, plus two limits that use the high byte. Each expected cycle count and length is computed from N, M and LINE_DEPTH.

// File: rtl/simctl_port.sv
module simctl_port #(
  parameter int          LINE_DEPTH = 64,
  parameter logic [15:0] TMO_RESET  = 16'hFFFF,
  localparam int         LEN_W      = $clog2(LINE_DEPTH + 1),
  localparam int         IDX_W      = $clog2(LINE_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       io_addr,
  input  logic [7:0]       io_wdata,
  input  logic             io_wr,
  input  logic             io_rd,
  output logic [7:0]       io_rdata,
  output logic             pass_pulse,
  output logic             fail_pulse,
  output logic             dump_on_pulse,
  output logic             dump_off_pulse,
  output logic             dump_active,
  output logic             done,
  output logic             done_pass,
  output logic             done_fail,
  output logic             done_timeout,
  output logic             timeout_error,
  output logic             line_valid,
  output logic [LEN_W-1:0] line_len,
  input  logic [IDX_W-1:0] line_rd_idx,
  output logic [7:0]       line_rd_char,
  output logic             int_n
);
  localparam logic [2:0]       WIN    = 3'b100;
  localparam logic [4:0]       P_CMD  = 5'h00;
  localparam logic [4:0]       P_MSG  = 5'h01;
  localparam logic [4:0]       P_TCTL = 5'h02;
  localparam logic [4:0]       P_TLO  = 5'h03;
  localparam logic [4:0]       P_THI  = 5'h04;
  localparam logic [4:0]       P_CD   = 5'h10;
  localparam logic [7:0]       NL     = 8'h0A;
  localparam logic [LEN_W-1:0] FULL   = LEN_W'(LINE_DEPTH);

  wire       in_win = io_addr[7:5] == WIN;
  wire [4:0] off    = io_addr[4:0];
  wire wr_cmd  = io_wr && in_win && off == P_CMD;
  wire wr_msg  = io_wr && in_win && off == P_MSG;
  wire wr_tctl = io_wr && in_win && off == P_TCTL;
  wire wr_tlo  = io_wr && in_win && off == P_TLO;
  wire wr_thi  = io_wr && in_win && off == P_THI;
  wire wr_cd   = io_wr && in_win && off == P_CD;

  wire pass_ev = wr_cmd && io_wdata == 8'h01;
  wire fail_ev = wr_cmd && io_wdata == 8'h02;
  wire don_ev  = wr_cmd && io_wdata == 8'h03;
  wire doff_ev = wr_cmd && io_wdata == 8'h04;

  logic             tmo_en;
  logic [15:0]      tmo_cnt, tmo_max;
  logic [7:0]       cd;
  logic [LEN_W-1:0] len;
  logic [7:0]       lbuf [LINE_DEPTH];

  wire tmo_hit = tmo_en && tmo_cnt == tmo_max;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pass_pulse     <= 1'b0;
      fail_pulse     <= 1'b0;
      dump_on_pulse  <= 1'b0;
      dump_off_pulse <= 1'b0;
      dump_active    <= 1'b0;
    end else begin
      pass_pulse     <= pass_ev;
      fail_pulse     <= fail_ev;
      dump_on_pulse  <= don_ev;
      dump_off_pulse <= doff_ev;
      if (don_ev)       dump_active <= 1'b1;
      else if (doff_ev) dump_active <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done         <= 1'b0;
      done_pass    <= 1'b0;
      done_fail    <= 1'b0;
      done_timeout <= 1'b0;
    end else if (!done) begin
      if (pass_ev) begin
        done      <= 1'b1;
        done_pass <= 1'b1;
      end else if (fail_ev) begin
        done      <= 1'b1;
        done_fail <= 1'b1;
      end else if (tmo_hit) begin
        done         <= 1'b1;
        done_timeout <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmo_en        <= 1'b1;
      tmo_cnt       <= '0;
      tmo_max       <= TMO_RESET;
      timeout_error <= 1'b0;
    end else begin
      if (wr_tctl) tmo_en <= io_wdata[0];
      if (wr_tctl && io_wdata[1]) tmo_cnt <= '0;
      else if (tmo_en)            tmo_cnt <= tmo_cnt + 16'd1;
      if (wr_tlo) tmo_max[7:0]  <= io_wdata;
      if (wr_thi) tmo_max[15:8] <= io_wdata;
      if (tmo_hit) timeout_error <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cd    <= '0;
      int_n <= 1'b1;
    end else if (wr_cd) begin
      cd    <= io_wdata;
      int_n <= 1'b1;
    end else if (cd != 8'd0) begin
      cd <= cd - 8'd1;
      if (cd == 8'd1) int_n <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len        <= '0;
      line_valid <= 1'b0;
      line_len   <= '0;
    end else begin
      line_valid <= 1'b0;
      if (wr_msg) begin
        if (io_wdata == NL) begin
          line_valid <= 1'b1;
          line_len   <= len;
          len        <= '0;
        end else if (len != FULL) begin
          len <= len + LEN_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk)
    if (wr_msg && io_wdata != NL && len != FULL)
      lbuf[IDX_W'(len)] <= io_wdata;

  assign line_rd_char = lbuf[line_rd_idx];

  always_comb begin
    io_rdata = 8'h00;
    if (io_rd && in_win) begin
      case (off)
        P_TCTL:  io_rdata = {7'b0, tmo_en};
        P_TLO:   io_rdata = tmo_max[7:0];
        P_THI:   io_rdata = tmo_max[15:8];
        default: io_rdata = 8'h00;
      endcase
    end
  end
endmodule

module simctl_port_chk #(
  parameter int LINE_DEPTH = 64,
  parameter int LEN_W      = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       io_addr,
  input logic             io_wr,
  input logic             pass_pulse,
  input logic             fail_pulse,
  input logic             dump_on_pulse,
  input logic             dump_off_pulse,
  input logic             done,
  input logic             done_pass,
  input logic             done_fail,
  input logic             done_timeout,
  input logic             timeout_error,
  input logic [LEN_W-1:0] line_len,
  input logic             int_n
);
  localparam logic [LEN_W-1:0] FULL = LEN_W'(LINE_DEPTH);
  wire [3:0] pulses = {pass_pulse, fail_pulse, dump_on_pulse, dump_off_pulse};
  wire       cd_wr  = io_wr && io_addr == 8'h90;

  AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (io_wr && io_addr[7:5] != 3'b100) |=> pulses == 4'b0); // R1
  AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(pulses)); // R2
  AST_PASS_SHORT: assert property (@(posedge clk) disable iff (!rst_n) pass_pulse |=> !pass_pulse); // R2
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) done |=> done && $stable({done_pass, done_fail, done_timeout})); // R4
  AST_STATUS_MATCH: assert property (@(posedge clk) disable iff (!rst_n) $countones({done_pass, done_fail, done_timeout}) == (done ? 1 : 0)); // R4
  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n) line_len <= FULL); // R6
  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n) timeout_error |=> timeout_error); // R8
  AST_INT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!int_n && !cd_wr) |=> !int_n); // R10
  AST_INT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) cd_wr |=> int_n); // R11
endmodule

bind simctl_port simctl_port_chk #(.LINE_DEPTH(LINE_DEPTH), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
  .pass_pulse(pass_pulse), .fail_pulse(fail_pulse),
  .dump_on_pulse(dump_on_pulse), .dump_off_pulse(dump_off_pulse),
  .done(done), .done_pass(done_pass), .done_fail(done_fail), .done_timeout(done_timeout),
  .timeout_error(timeout_error), .line_len(line_len), .int_n(int_n)
);

// File: tb/simctl_port_test.sv
module simctl_port_test;
  localparam int          DEPTH = 8;
  localparam logic [15:0] TRST  = 16'd300;
  localparam int          LEN_W = $clog2(DEPTH + 1);
  localparam int          IDX_W = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] io_addr = 8'h00, io_wdata = 8'h00;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_rdata, line_rd_char;
  logic pass_pulse, fail_pulse, dump_on_pulse, dump_off_pulse, dump_active;
  logic done, done_pass, done_fail, done_timeout, timeout_error, line_valid, int_n;
  logic [LEN_W-1:0] line_len;
  logic [IDX_W-1:0] line_rd_idx = '0;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  simctl_port #(.LINE_DEPTH(DEPTH), .TMO_RESET(TRST)) uut (.*);

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    io_rd = 1'b1; io_addr = a;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic reset(input bit quiet);
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    if (quiet) wr(8'h82, 8'h00);
  endtask

  task automatic wait_tmo(output int k);
    k = 0;
    while (!timeout_error) begin @(negedge clk); k++; end
  endtask

  task automatic set_max(input int m);
    logic [7:0] b;
    wr(8'h83, 8'(m)); wr(8'h84, 8'(m >> 8));
    rd(8'h83, b); chk(b, m & 255, "R9 low byte");
    rd(8'h84, b); chk(b, m >> 8, "R9 high byte");
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_up();
  end

  initial begin
    logic [7:0] b;
    int k;
    bit dexp;

    reset(1'b0);
    rd(8'h82, b); chk(b, 1, "R8 enable after reset");
    rd(8'h83, b); chk(b, TRST[7:0], "R9 reset low byte");
    rd(8'h84, b); chk(b, TRST[15:8], "R9 reset high byte");
    chk({done, pass_pulse, dump_active, line_valid, timeout_error}, 0, "R4 reset outputs");
    chk(int_n, 1, "R10 reset int_n");
    wait_tmo(k);
    chk(k, TRST + 1, "R8 default expiry");
    chk({done, done_timeout}, 3, "R4 timeout sets done");

    reset(1'b1);
    wr(8'h00, 8'h01); chk(pass_pulse, 0, "R1 alias 0x00");
    wr(8'hA0, 8'h01); chk(pass_pulse, 0, "R1 alias 0xA0");
    wr(8'h85, 8'h01); chk(pass_pulse, 0, "R1 unused offset");
    wr(8'h41, 8'h41); wr(8'h01, 8'h0A); chk(line_valid, 0, "R1 alias message port");
    wr(8'h10, 8'h05); repeat (10) @(negedge clk); chk(int_n, 1, "R1 alias countdown");
    wr(8'hC2, 8'h02); wr(8'hC3, 8'h00);
    rd(8'h82, b); chk(b, 0, "R1 alias control");
    rd(8'h83, b); chk(b, TRST[7:0], "R1 alias limit");
    rd(8'hC3, b); chk(b, 0, "R9 read outside window");
    chk(done, 0, "R1 no done");

    dexp = 1'b0;
    for (int v = 0; v < 256; v++) begin
      if (v == 1 || v == 2) continue;
      wr(8'h80, 8'(v));
      if (v == 3) dexp = 1'b1;
      if (v == 4) dexp = 1'b0;
      chk({pass_pulse, fail_pulse, dump_on_pulse, dump_off_pulse}, {2'b00, v == 3, v == 4}, "R2 command pulse");
      chk(dump_active, dexp, "R3 dump level");
      @(negedge clk);
      chk({pass_pulse, fail_pulse, dump_on_pulse, dump_off_pulse}, 0, "R2 one-cycle pulse");
      if (v == 3) wr(8'h80, 8'h05);
      if (v == 3) chk(dump_active, 1, "R3 other value keeps level");
    end
    chk(done, 0, "R2 no done from other codes");
    wr(8'h80, 8'h01);
    chk(pass_pulse, 1, "R2 pass pulse");
    chk({done, done_pass, done_fail, done_timeout}, 4'b1100, "R4 pass first");
    wr(8'h80, 8'h02);
    chk(fail_pulse, 1, "R2 fail pulse");
    chk({done, done_pass, done_fail, done_timeout}, 4'b1100, "R4 fail after pass");
    set_max(3); wr(8'h82, 8'h03); wait_tmo(k);
    chk({done, done_pass, done_fail, done_timeout}, 4'b1100, "R4 timeout after pass");

    reset(1'b1);
    wr(8'h80, 8'h02);
    wr(8'h80, 8'h01);
    chk({done, done_pass, done_fail, done_timeout}, 4'b1010, "R4 fail first");

    for (int m = 0; m <= 42; m++) begin
      int mm;
      mm = (m == 41) ? 256 : (m == 42) ? 300 : m;
      reset(1'b1);
      set_max(mm);
      wr(8'h82, 8'h03);
      wait_tmo(k);
      chk(k, mm + 1, "R8 limit expiry");
      chk(done_timeout, 1, "R4 timeout status");
    end

    reset(1'b1);
    set_max(5);
    wr(8'h82, 8'h02);
    repeat (50) @(negedge clk);
    chk(timeout_error, 0, "R7 disabled holds");
    rd(8'h82, b); chk(b, 0, "R7 enable readback");
    wr(8'h82, 8'h01);
    rd(8'h82, b); chk(b, 1, "R7 enable readback set");
    wait_tmo(k);
    chk(k, 6, "R7 resume count");

    reset(1'b1);
    set_max(10);
    wr(8'h82, 8'h03);
    repeat (5) @(negedge clk);
    wr(8'h82, 8'h03);
    wait_tmo(k);
    chk(k, 11, "R7 mid-run clear");

    reset(1'b1);
    for (int n = 1; n < 256; n++) begin
      wr(8'h90, 8'(n));
      chk(int_n, 1, "R10 reload releases");
      k = 0;
      while (int_n) begin @(negedge clk); k++; end
      chk(k, n, "R10 countdown length");
      repeat (3) @(negedge clk);
      chk(int_n, 0, "R10 held low");
    end
    wr(8'h90, 8'h00);
    chk(int_n, 1, "R11 zero releases");
    wr(8'h90, 8'd20);
    repeat (5) @(negedge clk);
    wr(8'h90, 8'h00);
    repeat (40) @(negedge clk);
    chk(int_n, 1, "R11 cancel pending");

    for (int l = 0; l <= 12; l++) begin
      int exp_len;
      exp_len = (l < DEPTH) ? l : DEPTH;
      for (int i = 0; i < l; i++) wr(8'h81, 8'(l * 16 + i));
      chk(line_valid, 0, "R5 no strobe before newline");
      wr(8'h81, 8'h0A);
      chk(line_valid, 1, "R5 newline strobe");
      chk(line_len, exp_len, (l > DEPTH) ? "R6 capped length" : "R5 line length");
      for (int i = 0; i < exp_len; i++) begin
        line_rd_idx = IDX_W'(i);
        #1 chk(line_rd_char, l * 16 + i, (l > DEPTH) ? "R6 dropped tail" : "R5 line content");
      end
      @(negedge clk);
      chk(line_valid, 0, "R5 one-cycle strobe");
      chk(line_len, exp_len, "R5 length held");
    end

    finish_up();
  end
endmodule